// File: doc/BRIEF.md
# Programmable Address Window Decoder

The decoder maps a 32-bit processor address onto one of thirteen targets. Each target has a programmable window, and the decoder drives a one-hot select plus a miss flag. Four coarse windows serve memory chip selects and match on the top byte of the address. Eight finer windows serve general on-chip targets and match on the top sixteen bits. One window of fixed 1MB size covers the internal registers. It can be moved by a processor write to a register that sits inside that window.

A size field is a mask of contiguous low ones. Masked address bits take no part in the compare. The window therefore spans (mask+1) granules of 16MB or 64KB, and the all-ones mask spans the whole 4GB space. A single-cycle configuration port writes and reads window bases, sizes and enables. A write whose size is not a legal mask is refused and sets a sticky error.

The path from address to select is combinational. Every register write takes effect at the clock edge that samples the write strobe.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, memory window k (k=0..3) has base 0x10*k and size 0x0F, so it covers 256MB starting at k*0x10000000. The general windows hold these base/size pairs: 0 is 0x8000/0x1FFF, 1 is 0xC000/0x0001, 2 is 0xD800/0x07FF, 3 is 0xE800/0x07FF, 4 is 0xF000/0x07FF and 5 is 0xF800/0x07FF. Windows 6 and 7 are 0x0000/0x0001. The enable register reads 0x3FF, the register window base is 0xD00 (0xD0000000), and the error flag is 0.
- R2: An enabled memory window k (select bit k) hits when address bits [31:24] equal its 8-bit base in every bit position where its size mask is 0.
- R3: An enabled general window g (select bit 4+g) hits when address bits [31:16] equal its 16-bit base in every bit position where its size mask is 0.
- R4: The register window (select bit 12) is always enabled. It hits exactly when address bits [31:20] equal its 12-bit base.
- R5: A bus write (bus_wr=1) to register-window offset 0x20080 loads bus_wdata[31:20] into the register window base at the next edge. A bus write at any other address leaves the base unchanged. In the same cycle, a configuration write to index 12 takes precedence.
- R6: A configuration write to a memory or general window applies only when its size field is a nonzero run of contiguous low ones. Otherwise the base and size both keep their old values and the error flag is set. The flag stays set until a configuration write to index 14 with data bit 0 set.
- R7: When several windows hit, win_sel holds one bit only. The register window wins first, then memory windows 0..3 in order, then general windows 0..7 in order.
- R8: When no enabled window hits, win_sel is all zero and miss is 1 in the same cycle. Otherwise miss is 0.
- R9: Enable bits [11:0] are written at index 13 (bit k for memory window k, bit 4+g for general window g). A window whose enable bit is 0 never hits.
- R10: Configuration map: index 0..3 carries memory base in [7:0] and size in [23:16]. Index 4..11 carries general base in [15:0] and size in [31:16]. Index 12 carries the register base in [31:20], index 13 the enables, and index 14 the error flag in bit 0. Unused indices and bits read 0. cfg_rdata reflects cfg_idx combinationally, and a write is visible from the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the default map |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_idx |
| bus_addr | input | 32 | Processor address to decode |
| bus_wr | input | 1 | Processor write qualifier for bus_addr |
| bus_wdata | input | 32 | Processor write data |
| win_sel | output | 13 | One-hot target select |
| miss | output | 1 | No enabled window hits bus_addr |
| size_err | output | 1 | Sticky flag for a refused size write |

## Verification
The properties assume that bus_addr, bus_wr and the configuration inputs are stable across each clock edge and never unknown after reset. They also assume that a bus write and a configuration write to index 12 are not treated as ordered except by the stated precedence. The stimulus changes every input only on the falling edge, out of reset. It covers overlapping windows, edge addresses on both sides of each window, and legal and illegal masks. It moves the register window over a general window so that the priority and relocation properties are both reached.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int MEM_N    = 4,
  parameter int GEN_N    = 8,
  parameter int MEM_W    = 8,
  parameter int GEN_W    = 16,
  parameter int REGWIN_W = 12,
  parameter int REG_OFS  = 'h20080,
  parameter int REG_RST  = 'hD00,
  localparam int NW      = MEM_N + GEN_N + 1,
  localparam int IW      = $clog2(NW + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [IW-1:0] cfg_idx,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [31:0]   bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [NW-1:0] win_sel,
  output logic          miss,
  output logic          size_err
);
  localparam int LOW_W   = 32 - REGWIN_W;
  localparam int IDX_REG = MEM_N + GEN_N;
  localparam int IDX_EN  = IDX_REG + 1;
  localparam int IDX_ERR = IDX_REG + 2;

  logic [MEM_W-1:0]      mbase [MEM_N];
  logic [MEM_W-1:0]      msize [MEM_N];
  logic [GEN_W-1:0]      gbase [GEN_N];
  logic [GEN_W-1:0]      gsize [GEN_N];
  logic [REGWIN_W-1:0]   rbase;
  logic [NW-2:0]         wen;
  logic [NW-2:0]         hits;
  logic                  rhit;

  wire unused_bits = ^{cfg_wdata, bus_wdata};

  function automatic logic mem_ok(input logic [MEM_W-1:0] s);
    return (s != '0) && ((s & (s + 1'b1)) == '0);
  endfunction

  function automatic logic gen_ok(input logic [GEN_W-1:0] s);
    return (s != '0) && ((s & (s + 1'b1)) == '0);
  endfunction

  function automatic logic [GEN_W-1:0] gdef_base(input int i);
    case (i)
      0: return GEN_W'(16'h8000);
      1: return GEN_W'(16'hC000);
      2: return GEN_W'(16'hD800);
      3: return GEN_W'(16'hE800);
      4: return GEN_W'(16'hF000);
      5: return GEN_W'(16'hF800);
      default: return '0;
    endcase
  endfunction

  function automatic logic [GEN_W-1:0] gdef_size(input int i);
    case (i)
      0: return GEN_W'(16'h1FFF);
      2, 3, 4, 5: return GEN_W'(16'h07FF);
      default: return GEN_W'(16'h0001);
    endcase
  endfunction

  assign rhit = bus_addr[31-:REGWIN_W] == rbase;

  wire reloc = bus_wr && rhit && (bus_addr[LOW_W-1:0] == LOW_W'(REG_OFS)) &&
               !(cfg_wr && cfg_idx == IW'(IDX_REG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) begin
        mbase[i] <= MEM_W'(16 * i);
        msize[i] <= MEM_W'(8'h0F);
      end
      for (int i = 0; i < GEN_N; i++) begin
        gbase[i] <= gdef_base(i);
        gsize[i] <= gdef_size(i);
      end
      rbase    <= REGWIN_W'(REG_RST);
      wen      <= (NW-1)'(12'h3FF);
      size_err <= 1'b0;
    end else begin
      if (cfg_wr) begin
        for (int i = 0; i < MEM_N; i++)
          if (cfg_idx == IW'(i)) begin
            if (mem_ok(cfg_wdata[16+:MEM_W])) begin
              mbase[i] <= cfg_wdata[0+:MEM_W];
              msize[i] <= cfg_wdata[16+:MEM_W];
            end else size_err <= 1'b1;
          end
        for (int i = 0; i < GEN_N; i++)
          if (cfg_idx == IW'(MEM_N + i)) begin
            if (gen_ok(cfg_wdata[16+:GEN_W])) begin
              gbase[i] <= cfg_wdata[0+:GEN_W];
              gsize[i] <= cfg_wdata[16+:GEN_W];
            end else size_err <= 1'b1;
          end
        if (cfg_idx == IW'(IDX_REG)) rbase <= cfg_wdata[31-:REGWIN_W];
        if (cfg_idx == IW'(IDX_EN))  wen   <= cfg_wdata[NW-2:0];
        if (cfg_idx == IW'(IDX_ERR) && cfg_wdata[0]) size_err <= 1'b0;
      end
      if (reloc) rbase <= bus_wdata[31-:REGWIN_W];
    end
  end

  for (genvar i = 0; i < MEM_N; i++) begin : g_mem
    assign hits[i] = wen[i] &&
      ((bus_addr[31-:MEM_W] & ~msize[i]) == (mbase[i] & ~msize[i]));
  end
  for (genvar i = 0; i < GEN_N; i++) begin : g_gen
    assign hits[MEM_N+i] = wen[MEM_N+i] &&
      ((bus_addr[31-:GEN_W] & ~gsize[i]) == (gbase[i] & ~gsize[i]));
  end

  always_comb begin
    logic found;
    win_sel = '0;
    found   = rhit;
    win_sel[NW-1] = rhit;
    for (int i = 0; i < NW - 1; i++)
      if (hits[i] && !found) begin
        win_sel[i] = 1'b1;
        found = 1'b1;
      end
  end

  assign miss = !rhit && (hits == '0);

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < MEM_N; i++)
      if (cfg_idx == IW'(i)) begin
        cfg_rdata[0+:MEM_W]  = mbase[i];
        cfg_rdata[16+:MEM_W] = msize[i];
      end
    for (int i = 0; i < GEN_N; i++)
      if (cfg_idx == IW'(MEM_N + i)) begin
        cfg_rdata[0+:GEN_W]  = gbase[i];
        cfg_rdata[16+:GEN_W] = gsize[i];
      end
    if (cfg_idx == IW'(IDX_REG)) cfg_rdata[31-:REGWIN_W] = rbase;
    if (cfg_idx == IW'(IDX_EN))  cfg_rdata[NW-2:0] = wen;
    if (cfg_idx == IW'(IDX_ERR)) cfg_rdata[0] = size_err;
  end
endmodule

module addr_window_decoder_chk #(
  parameter int MEM_N    = 4,
  parameter int GEN_N    = 8,
  parameter int MEM_W    = 8,
  parameter int REGWIN_W = 12,
  parameter int REG_OFS  = 'h20080,
  localparam int NW      = MEM_N + GEN_N + 1,
  localparam int IW      = $clog2(NW + 2),
  localparam int LOW_W   = 32 - REGWIN_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_wr,
  input logic [IW-1:0]       cfg_idx,
  input logic [31:0]         cfg_wdata,
  input logic [31:0]         bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [NW-1:0]       win_sel,
  input logic                miss,
  input logic                size_err,
  input logic [REGWIN_W-1:0] rbase
);
  wire [MEM_W-1:0] wsz = cfg_wdata[16+:MEM_W];
  wire mem_bad = (wsz == '0) || ((wsz & (wsz + 1'b1)) != '0);
  wire err_clr = cfg_wr && cfg_idx == IW'(MEM_N + GEN_N + 2) && cfg_wdata[0];
  wire reg_cfg = cfg_wr && cfg_idx == IW'(MEM_N + GEN_N);

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));

  p_miss_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss == (win_sel == '0));

  p_reg_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[31-:REGWIN_W] == rbase) |-> win_sel[NW-1]);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size_err && !err_clr) |=> size_err);

  p_bad_mem_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx < IW'(MEM_N) && mem_bad) |=> size_err);

  p_reloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && win_sel[NW-1] && bus_addr[LOW_W-1:0] == LOW_W'(REG_OFS) && !reg_cfg)
      |=> rbase == $past(bus_wdata[31-:REGWIN_W]));

  p_no_reloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !reg_cfg) |=> $stable(rbase));
endmodule

bind addr_window_decoder addr_window_decoder_chk #(
  .MEM_N(MEM_N), .GEN_N(GEN_N), .MEM_W(MEM_W), .REGWIN_W(REGWIN_W), .REG_OFS(REG_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .win_sel(win_sel),
  .miss(miss), .size_err(size_err), .rbase(rbase)
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0, bus_wr = 0;
  logic [3:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0, bus_addr = 0, bus_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [12:0] win_sel;
  logic        miss, size_err;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  int mb[4], ms[4], gb[8], gs[8];
  int en, rb;
  bit er;

  addr_window_decoder i_addr_window_decoder (.*);

  always #5 clk = ~clk;

  function automatic bit legal(int s, int w);
    for (int k = 1; k <= w; k++) if (s == (1 << k) - 1) return 1;
    return 0;
  endfunction

  function automatic bit inwin(longint a, longint b, longint s, int sh);
    longint lo = (b - (b % (s + 1))) << sh;
    return a >= lo && a < lo + ((s + 1) << sh);
  endfunction

  function automatic logic [12:0] exp_sel(logic [31:0] a);
    longint ad = longint'(a);
    if (ad >= (longint'(rb) << 20) && ad < (longint'(rb) << 20) + 64'h100000) return 13'h1000;
    for (int i = 0; i < 4; i++)
      if (en[i] && inwin(ad, mb[i], ms[i], 24)) return 13'(1 << i);
    for (int i = 0; i < 8; i++)
      if (en[4+i] && inwin(ad, gb[i], gs[i], 16)) return 13'(1 << (4 + i));
    return '0;
  endfunction

  function automatic logic [31:0] exp_rd(int idx);
    if (idx < 4) return 32'(ms[idx] * 65536 + mb[idx]);
    if (idx < 12) return 32'(gs[idx-4] * 65536 + gb[idx-4]);
    if (idx == 12) return 32'(rb) << 20;
    if (idx == 13) return 32'(en);
    if (idx == 14) return 32'(er);
    return 0;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin mb[k] = 16 * k; ms[k] = 15; end
    gb = '{'h8000, 'hC000, 'hD800, 'hE800, 'hF000, 'hF800, 0, 0};
    gs = '{'h1FFF, 1, 'h7FF, 'h7FF, 'h7FF, 'h7FF, 1, 1};
    en = 'h3FF; rb = 'hD00; er = 0;
  endtask

  task automatic model_step();
    int idx = int'(cfg_idx);
    bit mv = bus_wr && (exp_sel(bus_addr) == 13'h1000) &&
             (bus_addr - (32'(rb) << 20)) == 32'h20080 && !(cfg_wr && idx == 12);
    if (cfg_wr) begin
      if (idx < 4) begin
        if (legal(int'(cfg_wdata[23:16]), 8)) begin mb[idx] = cfg_wdata[7:0]; ms[idx] = cfg_wdata[23:16]; end
        else er = 1;
      end else if (idx < 12) begin
        if (legal(int'(cfg_wdata[31:16]), 16)) begin gb[idx-4] = cfg_wdata[15:0]; gs[idx-4] = cfg_wdata[31:16]; end
        else er = 1;
      end else if (idx == 12) rb = cfg_wdata[31:20];
      else if (idx == 13) en = cfg_wdata[11:0];
      else if (idx == 14 && cfg_wdata[0]) er = 0;
    end
    if (mv) rb = bus_wdata[31:20];
  endtask

  task automatic cyc();
    logic [12:0] es;
    #2;
    es = exp_sel(bus_addr);
    checks++;
    if (win_sel !== es || miss !== (es == 0) || size_err !== er || cfg_rdata !== exp_rd(int'(cfg_idx))) begin
      fails++;
      $display("FAIL %s addr=%h idx=%0d: sel=%h miss=%b err=%b rd=%h expected sel=%h miss=%b err=%b rd=%h",
        phase, bus_addr, cfg_idx, win_sel, miss, size_err, cfg_rdata, es, es == 0, er, exp_rd(int'(cfg_idx)));
    end
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  task automatic look(logic [31:0] a, int idx = 0);
    bus_addr = a; cfg_idx = 4'(idx); cyc();
  endtask

  task automatic wr(int idx, logic [31:0] d);
    cfg_wr = 1; cfg_idx = 4'(idx); cfg_wdata = d; cyc();
    cfg_wr = 0; cyc();
  endtask

  task automatic bwr(logic [31:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; cyc();
    bus_wr = 0; cyc();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    for (int k = 0; k < 15; k++) look(32'h0, k);
    foreach (gb[g]) look(32'(gb[g]) << 16);
    look(32'h3FFF_FFFF); look(32'hC001_FFFF); look(32'hC002_0000);
    look(32'h4000_0000); look(32'hFFFF_FFFF); look(32'hA000_0000);

    phase = "R4";
    look(32'hD000_0000); look(32'hD00F_FFFF); look(32'hD010_0000); look(32'hCFFF_FFFF);

    phase = "R3";
    wr(10, 32'h0003_4801); wr(13, 32'h7FF);
    look(32'h4800_0000, 10); look(32'h4803_FFFF); look(32'h4804_0000); look(32'h47FF_FFFF);
    wr(11, 32'h0000_4900 | 32'h0001_0000); look(32'h4901_0000, 11); look(32'h4902_0000);

    phase = "R9";
    wr(13, 32'h7FE); look(32'h0000_0000, 13); look(32'h0FFF_FFFF); look(32'h1000_0000);
    wr(13, 32'hBFF); look(32'h4800_0000); wr(13, 32'hFFF);

    phase = "R2";
    wr(0, 32'h0003_0041); look(32'h4000_0000, 0); look(32'h43FF_FFFF); look(32'h4400_0000);
    look(32'h0000_0000); look(32'h3FFF_FFFF);

    phase = "R7";
    look(32'h4800_0000);
    wr(1, 32'h00FF_0000);
    look(32'h4800_0000); look(32'h4000_0000); look(32'h8000_0000); look(32'hD000_1234);
    wr(1, 32'h000F_0010);

    phase = "R5";
    bwr(32'hD002_0084, 32'hF100_0000); look(32'hD000_0000, 12);
    bwr(32'hD002_0080, 32'hF100_0000); look(32'hD000_0000, 12);
    look(32'hF100_0000); look(32'hF10F_FFFF); look(32'hF110_0000);
    cfg_wr = 1; cfg_idx = 12; cfg_wdata = 32'hE000_0000;
    bus_wr = 1; bus_addr = 32'hF102_0080; bus_wdata = 32'hB000_0000; cyc();
    cfg_wr = 0; bus_wr = 0; look(32'hE000_0000, 12); look(32'hB000_0000);
    bwr(32'hE002_0080, 32'hF100_0000); look(32'hF100_0000, 12);

    phase = "R6";
    wr(2, 32'h0005_0050); look(32'h2000_0000, 2); look(32'h5000_0000, 14);
    wr(9, 32'h0000_1234); look(32'h0, 9);
    wr(3, 32'h0000_0060); look(32'h3000_0000, 3);
    wr(14, 32'h0); look(32'h0, 14);
    wr(14, 32'h1); look(32'h0, 14);
    wr(4, 32'h0101_9000); look(32'h8000_0000, 4);

    phase = "R8";
    wr(13, 32'h0); look(32'h0000_0000); look(32'h8000_0000); look(32'hF100_0000);
    wr(13, 32'h3FF);

    phase = "R10";
    cfg_wr = 1; cfg_idx = 5; cfg_wdata = 32'h0007_7000; bus_addr = 32'h7000_0000; cyc();
    cfg_wr = 0; cyc(); look(32'h7007_FFFF, 5); look(32'h0, 15);

    phase = "R7";
    for (int n = 0; n < 400; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[3:0] == 0) begin
        cfg_wr = 1; cfg_idx = 4'(lcg[7:4] % 14);
        cfg_wdata = (cfg_idx == 12) ? 32'hF100_0000 :
                    {lcg[24] ? 16'h00FF >> lcg[27:25] : lcg[31:16], lcg[15:0]};
        if (cfg_idx < 4) cfg_wdata[23:16] = lcg[9] ? 8'h0F >> lcg[11:10] : lcg[23:16];
      end else begin
        cfg_wr = 0; cfg_idx = 4'(lcg[11:8] % 15);
      end
      bus_addr = {lcg[31:24] ^ lcg[7:0], lcg[15:0], lcg[31:24]};
      cyc();
    end
    cfg_wr = 0;
    finish_run();
  end
endmodule